// File: doc/BRIEF.md
# CAM Host Control Register Block

This block sits between a host processor and a content-addressable match array. The host sees eight 16-bit registers on a simple write/read port. Four data registers hold a 64-bit entry, and a command register starts an operation. Three further registers report status: a flag word, an error code and an interrupt-enable word. Commands are mode selection, insert, delete, match, table initialise and setting the almost-full threshold. Each command is checked against the current state before anything reaches the array. A command that fails the check leaves a fault code and does nothing else.

There are two ways to insert. Fast inserts go straight to the array and mark the table as needing initialisation again. Buffered inserts are placed in a 12-deep entry queue. The queue drains into the array in arrival order whenever the array port is free. The array is reached through a request/acknowledge handshake. The block keeps its own count of table occupancy, which drives the full and almost-full flags.

Top module: `cam_cp_top`

## Requirements
- R1: After reset the flag word (offset 5) reads 0x0410 and the error code register (offset 6) reads 0xFFFF. Offsets 0-3 are data registers, 4 is the command register, 5 flags, 6 error code, 7 interrupt enable. Flag bits: 0 interrupt enabled, 1 last match hit, 2 table initialised, 3 buffered mode, 4 queue empty, 5 queue full, 6 table full, 7 error pending, 8 almost full, 10 last command complete.
- R2: The entry sent to the array is {reg3, reg2, reg1, reg0}, with reg0 in the low bits. It stays stable while `tbl_req` is high and `tbl_ack` is low. The array operation codes are 0 insert, 1 delete, 2 match, 3 initialise.
- R3: The entry queue holds up to QUEUE_DEPTH (12) entries and reports empty and full on flag bits 4 and 5. Its entries reach the array as inserts in the order they were written.
- R4: A buffered insert written while the queue is full leaves code 0xFFF8 and queues nothing.
- R5: A fault code stays in the error register until the next write to the command register. That write returns it to 0xFFFF, or to the new command's own code. Flag bit 7 is set exactly while the code is not 0xFFFF.
- R6: Command codes sit in bits 3:0 of the command write: 1 set mode (reg0 bit 0 selects buffered), 2 insert, 3 delete, 4 match, 5 initialise, 6 set almost-full threshold (reg0). Any other code leaves 0xFFFD and has no other effect. A command written while a host command waits on the array also leaves 0xFFFD and has no other effect.
- R7: Match or delete issued while the table is not initialised leaves 0xFFFB and makes no array request.
- R8: When the queue is not empty, a match leaves 0xFFFC. Delete, initialise and fast insert leave 0xFFFA.
- R9: Flag bit 6 is set when the occupancy count equals TABLE_DEPTH. A fast insert at that count, or a buffered insert when count plus queue occupancy reaches TABLE_DEPTH, leaves 0xFFF9.
- R10: Flag bit 8 is set while the occupancy count is at or above the programmed threshold. The count rises on each acknowledged insert and falls on each acknowledged delete that hits.
- R11: Flag bit 10 drops when a host command that needs the array is accepted. It rises again on that command's acknowledge.
- R12: A match acknowledge records the hit on flag bit 1. On a hit it loads return data bits 15:0 into reg0 and bits 31:16 into reg1. An acknowledged initialise sets flag bit 2, and an accepted fast insert clears it.
- R13: Flag bit 0 is set while the interrupt-enable register (offset 7, read/write) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| tbl_req | output | 1 | Request to the match array |
| tbl_op | output | 2 | Array operation: 0 insert, 1 delete, 2 match, 3 initialise |
| tbl_entry | output | 64 | Entry or key for the array operation |
| tbl_ack | input | 1 | Array completion, one cycle |
| tbl_hit | input | 1 | Match or delete found an entry, valid with ack |
| tbl_rdata | input | 32 | Match return data, valid with ack |

## Verification
The hardest states to reach are a full queue and a host command arriving while the array is busy. The queue normally drains as fast as entries arrive. The bench's array model therefore has a hold switch that withholds acknowledges. Twelve buffered inserts then fill the queue, the thirteenth can be refused, and match and delete meet a non-empty queue. The same hold keeps a match pending so that a second command write lands while it is in flight. Releasing the hold lets the drain order be compared against the write order.

// File: rtl/cam_cp_pkg.sv
package cam_cp_pkg;

   localparam int REG_W   = 16;
   localparam int NUM_IO  = 4;
   localparam int ENTRY_W = REG_W * NUM_IO;

   // register offsets
   localparam logic [2:0] OFS_CMD  = 3'd4;
   localparam logic [2:0] OFS_FLAG = 3'd5;
   localparam logic [2:0] OFS_ERR  = 3'd6;
   localparam logic [2:0] OFS_INTR = 3'd7;

   // host command codes
   localparam logic [3:0] CMD_MODE   = 4'h1;
   localparam logic [3:0] CMD_INSERT = 4'h2;
   localparam logic [3:0] CMD_DELETE = 4'h3;
   localparam logic [3:0] CMD_MATCH  = 4'h4;
   localparam logic [3:0] CMD_INIT   = 4'h5;
   localparam logic [3:0] CMD_THRESH = 4'h6;

   typedef enum logic [1:0] {
      ARR_INSERT = 2'd0,
      ARR_DELETE = 2'd1,
      ARR_MATCH  = 2'd2,
      ARR_INIT   = 2'd3
   } arr_op_e;

   // fault codes
   localparam logic [15:0] FLT_NONE      = 16'hFFFF;
   localparam logic [15:0] FLT_BAD_CMD   = 16'hFFFD;
   localparam logic [15:0] FLT_Q_BUSY_RD = 16'hFFFC;
   localparam logic [15:0] FLT_NO_INIT   = 16'hFFFB;
   localparam logic [15:0] FLT_Q_BUSY_WR = 16'hFFFA;
   localparam logic [15:0] FLT_TBL_FULL  = 16'hFFF9;
   localparam logic [15:0] FLT_Q_FULL    = 16'hFFF8;

   // flag word bit positions
   localparam int FB_INTR  = 0;
   localparam int FB_HIT   = 1;
   localparam int FB_INIT  = 2;
   localparam int FB_BUF   = 3;
   localparam int FB_QEMP  = 4;
   localparam int FB_QFUL  = 5;
   localparam int FB_TFUL  = 6;
   localparam int FB_ERR   = 7;
   localparam int FB_AFUL  = 8;
   localparam int FB_DONE  = 10;

endpackage

// File: rtl/cam_cp_entry_queue.sv
module cam_cp_entry_queue #(
   parameter int WIDTH = 64,
   parameter int DEPTH = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push,
   input  logic [WIDTH-1:0]              push_data,
   input  logic                          pop,
   output logic [WIDTH-1:0]              head,
   output logic [$clog2(DEPTH+1)-1:0]    count,
   output logic                          empty,
   output logic                          full
);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = ((1 << PTR_W) == DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("cam_cp_entry_queue: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] slots [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = slots[rd_ptr];

   if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slots[wr_ptr] <= push_data;
   end

endmodule

// File: rtl/cam_cp_cmd_ctrl.sv
module cam_cp_cmd_ctrl
   import cam_cp_pkg::*;
#(
   parameter int TABLE_DEPTH = 4096,
   parameter int QUEUE_DEPTH = 12
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cmd_we,
   input  logic [3:0]                         cmd_code,
   input  logic [ENTRY_W-1:0]                 host_entry,
   input  logic [REG_W-1:0]                   arg_word,
   input  logic [$clog2(QUEUE_DEPTH+1)-1:0]   q_count,
   input  logic                               q_empty,
   input  logic                               q_full,
   input  logic [ENTRY_W-1:0]                 q_head,
   output logic                               q_push,
   output logic                               q_pop,
   output logic                               tbl_req,
   output arr_op_e                            tbl_op,
   output logic [ENTRY_W-1:0]                 tbl_entry,
   input  logic                               tbl_ack,
   input  logic                               tbl_hit,
   output logic                               match_load,
   output logic [REG_W-1:0]                   fault,
   output logic                               done,
   output logic                               inited,
   output logic                               buffered,
   output logic                               last_hit,
   output logic [$clog2(TABLE_DEPTH+1)-1:0]   occ,
   output logic [REG_W-1:0]                   thresh
);
   localparam int TCW = $clog2(TABLE_DEPTH+1);

   typedef enum logic [1:0] {ST_IDLE, ST_HOST, ST_DRAIN} st_e;
   st_e state;

   logic            busy, issue, set_mode, set_thr, acked;
   arr_op_e         issue_op;
   logic [REG_W-1:0] verdict;
   logic [TCW:0]    pending;

   assign busy    = (state == ST_HOST);
   assign acked   = tbl_req && tbl_ack;
   assign pending = {1'b0, occ} + (TCW+1)'(q_count);
   assign q_pop   = acked && (state == ST_DRAIN);
   assign match_load = acked && (tbl_op == ARR_MATCH) && tbl_hit;

   always_comb begin
      verdict  = FLT_NONE;
      issue    = 1'b0;
      issue_op = ARR_INSERT;
      q_push   = 1'b0;
      set_mode = 1'b0;
      set_thr  = 1'b0;
      if (cmd_we) begin
         if (busy) begin
            verdict = FLT_BAD_CMD;
         end else begin
            unique case (cmd_code)
               CMD_MODE:   set_mode = 1'b1;
               CMD_THRESH: set_thr  = 1'b1;
               CMD_INSERT: begin
                  if (buffered) begin
                     if (q_full)
                        verdict = FLT_Q_FULL;
                     else if (pending >= (TCW+1)'(TABLE_DEPTH))
                        verdict = FLT_TBL_FULL;
                     else
                        q_push = 1'b1;
                  end else begin
                     if (!q_empty)
                        verdict = FLT_Q_BUSY_WR;
                     else if (occ == TCW'(TABLE_DEPTH))
                        verdict = FLT_TBL_FULL;
                     else begin
                        issue    = 1'b1;
                        issue_op = ARR_INSERT;
                     end
                  end
               end
               CMD_DELETE: begin
                  if (!q_empty)    verdict = FLT_Q_BUSY_WR;
                  else if (!inited) verdict = FLT_NO_INIT;
                  else begin
                     issue    = 1'b1;
                     issue_op = ARR_DELETE;
                  end
               end
               CMD_MATCH: begin
                  if (!q_empty)    verdict = FLT_Q_BUSY_RD;
                  else if (!inited) verdict = FLT_NO_INIT;
                  else begin
                     issue    = 1'b1;
                     issue_op = ARR_MATCH;
                  end
               end
               CMD_INIT: begin
                  if (!q_empty) verdict = FLT_Q_BUSY_WR;
                  else begin
                     issue    = 1'b1;
                     issue_op = ARR_INIT;
                  end
               end
               default: verdict = FLT_BAD_CMD;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         tbl_req   <= 1'b0;
         tbl_op    <= ARR_INSERT;
         tbl_entry <= '0;
         fault     <= FLT_NONE;
         done      <= 1'b1;
         inited    <= 1'b0;
         buffered  <= 1'b0;
         last_hit  <= 1'b0;
         occ       <= '0;
         thresh    <= REG_W'(TABLE_DEPTH);
      end else begin
         if (cmd_we) begin
            fault <= verdict;
            if (!busy) done <= !issue;
         end
         if (set_mode) buffered <= arg_word[0];
         if (set_thr)  thresh   <= arg_word;

         if (acked) begin
            tbl_req <= 1'b0;
            state   <= ST_IDLE;
            if (state == ST_HOST) done <= 1'b1;
            unique case (tbl_op)
               ARR_INSERT: occ <= occ + 1'b1;
               ARR_DELETE: if (tbl_hit && occ != '0) occ <= occ - 1'b1;
               ARR_MATCH:  last_hit <= tbl_hit;
               ARR_INIT:   inited <= 1'b1;
            endcase
         end else if (issue) begin
            state     <= ST_HOST;
            tbl_req   <= 1'b1;
            tbl_op    <= issue_op;
            tbl_entry <= host_entry;
            if (issue_op == ARR_INSERT) inited <= 1'b0;
         end else if (state == ST_IDLE && !q_empty) begin
            state     <= ST_DRAIN;
            tbl_req   <= 1'b1;
            tbl_op    <= ARR_INSERT;
            tbl_entry <= q_head;
         end
      end
   end

endmodule

// File: rtl/cam_cp_top.sv
module cam_cp_top
   import cam_cp_pkg::*;
#(
   parameter int TABLE_DEPTH = 4096,
   parameter int QUEUE_DEPTH = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        tbl_req,
   output logic [1:0]  tbl_op,
   output logic [63:0] tbl_entry,
   input  logic        tbl_ack,
   input  logic        tbl_hit,
   input  logic [31:0] tbl_rdata
);
   localparam int TCW = $clog2(TABLE_DEPTH+1);
   localparam int QCW = $clog2(QUEUE_DEPTH+1);

   if (TABLE_DEPTH < 1 || TABLE_DEPTH > 65535) begin : g_bad_table
      $error("cam_cp_top: TABLE_DEPTH must lie in 1..65535");
   end
   if (QUEUE_DEPTH < 1) begin : g_bad_queue
      $error("cam_cp_top: QUEUE_DEPTH must be at least 1");
   end

   logic [REG_W-1:0]   io_reg [NUM_IO];
   logic [REG_W-1:0]   intr_en;
   logic [ENTRY_W-1:0] host_entry, q_head, entry_bus;
   logic [QCW-1:0]     q_count;
   logic               q_empty, q_full, q_push, q_pop;
   logic               match_load, done, inited, buffered, last_hit;
   logic [TCW-1:0]     occ;
   logic [REG_W-1:0]   fault, thresh, flag_word;
   logic               cmd_we;
   arr_op_e            op_bus;

   assign cmd_we = reg_we && (reg_addr == OFS_CMD);

   for (genvar g = 0; g < NUM_IO; g++) begin : g_io
      assign host_entry[g*REG_W +: REG_W] = io_reg[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            io_reg[g] <= '0;
         end else if (match_load && g < 2) begin
            io_reg[g] <= tbl_rdata[g*REG_W +: REG_W];
         end else if (reg_we && reg_addr == 3'(g)) begin
            io_reg[g] <= reg_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              intr_en <= '0;
      else if (reg_we && reg_addr == OFS_INTR) intr_en <= reg_wdata;
   end

   cam_cp_entry_queue #(
      .WIDTH (ENTRY_W),
      .DEPTH (QUEUE_DEPTH)
   ) i_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (host_entry),
      .pop       (q_pop),
      .head      (q_head),
      .count     (q_count),
      .empty     (q_empty),
      .full      (q_full)
   );

   cam_cp_cmd_ctrl #(
      .TABLE_DEPTH (TABLE_DEPTH),
      .QUEUE_DEPTH (QUEUE_DEPTH)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (cmd_we),
      .cmd_code   (reg_wdata[3:0]),
      .host_entry (host_entry),
      .arg_word   (io_reg[0]),
      .q_count    (q_count),
      .q_empty    (q_empty),
      .q_full     (q_full),
      .q_head     (q_head),
      .q_push     (q_push),
      .q_pop      (q_pop),
      .tbl_req    (tbl_req),
      .tbl_op     (op_bus),
      .tbl_entry  (entry_bus),
      .tbl_ack    (tbl_ack),
      .tbl_hit    (tbl_hit),
      .match_load (match_load),
      .fault      (fault),
      .done       (done),
      .inited     (inited),
      .buffered   (buffered),
      .last_hit   (last_hit),
      .occ        (occ),
      .thresh     (thresh)
   );

   assign tbl_op    = op_bus;
   assign tbl_entry = entry_bus;

   always_comb begin
      flag_word          = '0;
      flag_word[FB_INTR] = (intr_en != '0);
      flag_word[FB_HIT]  = last_hit;
      flag_word[FB_INIT] = inited;
      flag_word[FB_BUF]  = buffered;
      flag_word[FB_QEMP] = q_empty;
      flag_word[FB_QFUL] = q_full;
      flag_word[FB_TFUL] = (occ == TCW'(TABLE_DEPTH));
      flag_word[FB_ERR]  = (fault != FLT_NONE);
      flag_word[FB_AFUL] = (REG_W'(occ) >= thresh);
      flag_word[FB_DONE] = done;
   end

   always_comb begin
      unique case (reg_addr)
         OFS_FLAG: reg_rdata = flag_word;
         OFS_ERR:  reg_rdata = fault;
         OFS_INTR: reg_rdata = intr_en;
         OFS_CMD:  reg_rdata = '0;
         default:  reg_rdata = io_reg[reg_addr[1:0]];
      endcase
   end

endmodule

// File: rtl/cam_cp_checker.sv
module cam_cp_checker #(
   parameter int TABLE_DEPTH = 4096,
   parameter int QUEUE_DEPTH = 12
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               reg_we,
   input logic [2:0]                         reg_addr,
   input logic [15:0]                        reg_wdata,
   input logic                               tbl_req,
   input logic                               tbl_ack,
   input logic [63:0]                        tbl_entry,
   input logic [$clog2(QUEUE_DEPTH+1)-1:0]   q_count,
   input logic [$clog2(TABLE_DEPTH+1)-1:0]   occ,
   input logic [15:0]                        fault
);
   logic cmd_wr, bad_code;
   assign cmd_wr   = reg_we && (reg_addr == 3'd4);
   assign bad_code = (reg_wdata[3:0] == 4'h0) || (reg_wdata[3:0] > 4'h6);

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) <= QUEUE_DEPTH);

   a_r9_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= TABLE_DEPTH);

   a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_req && !tbl_ack) |=> (tbl_req && $stable(tbl_entry)));

   a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_wr |=> $stable(fault));

   a_r6_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bad_code) |=> (fault == 16'hFFFD));

endmodule

bind cam_cp_top cam_cp_checker #(
   .TABLE_DEPTH (TABLE_DEPTH),
   .QUEUE_DEPTH (QUEUE_DEPTH)
) i_cam_cp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .tbl_req   (tbl_req),
   .tbl_ack   (tbl_ack),
   .tbl_entry (tbl_entry),
   .q_count   (q_count),
   .occ       (occ),
   .fault     (fault)
);

// File: tb/test_cam_cp_top.sv
module test_cam_cp_top;
   localparam int TD = 16;
   localparam int QD = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tbl_req;
   logic [1:0]  tbl_op;
   logic [63:0] tbl_entry;
   logic        tbl_ack;
   logic        tbl_hit;
   logic [31:0] tbl_rdata;

   logic        hold = 1'b0;
   logic        resp_hit = 1'b0;
   logic [31:0] resp_data = '0;
   logic [63:0] ins_log [64];
   int          ins_n = 0;
   int          dly = 0;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 0;

   always #10 clk = ~clk;

   cam_cp_top #(.TABLE_DEPTH(TD), .QUEUE_DEPTH(QD)) i_cam_cp_top (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_req(tbl_req),
      .tbl_op(tbl_op), .tbl_entry(tbl_entry), .tbl_ack(tbl_ack),
      .tbl_hit(tbl_hit), .tbl_rdata(tbl_rdata)
   );

   assign tbl_hit   = resp_hit;
   assign tbl_rdata = resp_data;

   // array model: acknowledges three cycles into a request unless held
   always @(posedge clk) begin
      if (!rst_n) begin
         tbl_ack <= 1'b0;
         dly     <= 0;
      end else begin
         tbl_ack <= 1'b0;
         if (tbl_req && !tbl_ack && !hold) begin
            if (dly == 2) begin
               tbl_ack <= 1'b1;
               dly     <= 0;
               if (tbl_op == 2'd0 && ins_n < 64) begin
                  ins_log[ins_n] <= tbl_entry;
                  ins_n <= ins_n + 1;
               end
            end else begin
               dly <= dly + 1;
            end
         end
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic cmd(input logic [3:0] c);
      wr(3'd4, {12'h0, c});
   endtask

   task automatic wait_idle();
      logic [15:0] f;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         rd(3'd5, f);
         if (!tbl_req && f[4] && f[10]) break;
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(3'd5, v); chk("R1 flag reset", v, 16'h0410);
      rd(3'd6, v); chk("R1 error reset", v, 16'hFFFF);
   endtask

   task automatic t_bad_code();
      logic [15:0] v;
      cmd(4'hF);
      rd(3'd6, v); chk("R6 bad code fault", v, 16'hFFFD);
      rd(3'd5, v); chk("R6 bad code no effect, R5 err flag", v, 16'h0490);
      wr(3'd0, 16'h0000);
      rd(3'd6, v); chk("R5 fault held over data write", v, 16'hFFFD);
      cmd(4'h1);
      rd(3'd6, v); chk("R5 cleared by command write", v, 16'hFFFF);
      rd(3'd5, v); chk("R5 err flag cleared", v[7], 1'b0);
   endtask

   task automatic t_uninit();
      logic [15:0] v;
      cmd(4'h4);
      rd(3'd6, v); chk("R7 match before init", v, 16'hFFFB);
      chk("R7 no request", tbl_req, 1'b0);
      cmd(4'h3);
      rd(3'd6, v); chk("R7 delete before init", v, 16'hFFFB);
   endtask

   task automatic t_fast_insert();
      logic [15:0] v;
      wr(3'd0, 16'h1111); wr(3'd1, 16'h2222); wr(3'd2, 16'h3333); wr(3'd3, 16'h4444);
      cmd(4'h2);
      chk("R2 request raised", tbl_req, 1'b1);
      chk("R2 entry order", tbl_entry, 64'h4444_3333_2222_1111);
      chk("R2 insert op", tbl_op, 2'd0);
      rd(3'd5, v); chk("R11 done low while busy", v[10], 1'b0);
      wait_idle();
      rd(3'd5, v); chk("R11 done after ack", v[10], 1'b1);
      cmd(4'h5);
      chk("R2 init op", tbl_op, 2'd3);
      wait_idle();
      rd(3'd5, v); chk("R12 initialised", v[2], 1'b1);
   endtask

   task automatic t_queue();
      logic [15:0] v;
      hold = 1'b1;
      wr(3'd1, 16'h0); wr(3'd2, 16'h0); wr(3'd3, 16'h0);
      wr(3'd0, 16'h0001); cmd(4'h1);
      rd(3'd5, v); chk("R1 buffered mode bit", v[3], 1'b1);
      for (int k = 1; k <= QD; k++) begin
         wr(3'd0, 16'(k)); cmd(4'h2);
      end
      rd(3'd5, v);
      chk("R3 queue full flag", v[5], 1'b1);
      chk("R3 queue not empty", v[4], 1'b0);
      wr(3'd0, 16'h00EE); cmd(4'h2);
      rd(3'd6, v); chk("R4 push when full", v, 16'hFFF8);
      cmd(4'h4);
      rd(3'd6, v); chk("R8 match with queue", v, 16'hFFFC);
      cmd(4'h3);
      rd(3'd6, v); chk("R8 delete with queue", v, 16'hFFFA);
      cmd(4'h5);
      rd(3'd6, v); chk("R8 init with queue", v, 16'hFFFA);
      hold = 1'b0;
      wait_idle();
      chk("R3 drained count", ins_n, 1 + QD);
      for (int k = 1; k <= QD; k++)
         chk("R3 drain order", ins_log[k], 64'(k));
      rd(3'd5, v); chk("R3 queue empty", v[5:4], 2'b01);
   endtask

   task automatic t_thresh();
      logic [15:0] v;
      wr(3'd0, 16'd14); cmd(4'h6);
      rd(3'd5, v); chk("R10 below threshold", v[8], 1'b0);
      wr(3'd0, 16'h0077); cmd(4'h2);
      wait_idle();
      rd(3'd5, v); chk("R10 at threshold", v[8], 1'b1);
   endtask

   task automatic t_match();
      logic [15:0] v;
      resp_hit = 1'b1; resp_data = 32'hCAFE_0BAD;
      hold = 1'b1;
      cmd(4'h4);
      chk("R2 match op", tbl_op, 2'd2);
      wr(3'd0, 16'h0000);
      cmd(4'h1);
      rd(3'd6, v); chk("R6 command while busy", v, 16'hFFFD);
      rd(3'd5, v);
      chk("R6 busy command no mode change", v[3], 1'b1);
      chk("R11 done still low", v[10], 1'b0);
      hold = 1'b0;
      wait_idle();
      rd(3'd0, v); chk("R12 return low", v, 16'h0BAD);
      rd(3'd1, v); chk("R12 return high", v, 16'hCAFE);
      rd(3'd5, v); chk("R12 hit flag", v[1], 1'b1);
      rd(3'd6, v); chk("R5 ack leaves fault", v, 16'hFFFD);
   endtask

   task automatic t_delete();
      logic [15:0] v;
      cmd(4'h3);
      wait_idle();
      rd(3'd5, v); chk("R10 delete lowers count", v[8], 1'b0);
      resp_hit = 1'b0;
      cmd(4'h4);
      wait_idle();
      rd(3'd5, v); chk("R12 miss flag", v[1], 1'b0);
   endtask

   task automatic t_full();
      logic [15:0] v;
      wr(3'd0, 16'h0000); cmd(4'h1);
      wr(3'd0, 16'h0100); cmd(4'h2);
      rd(3'd5, v); chk("R12 fast insert clears init", v[2], 1'b0);
      wait_idle();
      wr(3'd0, 16'h0001); cmd(4'h1);
      wr(3'd0, 16'h0101); cmd(4'h2);
      wr(3'd0, 16'h0102); cmd(4'h2);
      wait_idle();
      rd(3'd5, v); chk("R9 table full flag", v[6], 1'b1);
      wr(3'd0, 16'h0103); cmd(4'h2);
      rd(3'd6, v); chk("R9 buffered insert when full", v, 16'hFFF9);
      rd(3'd5, v); chk("R9 nothing queued", v[4], 1'b1);
      wr(3'd0, 16'h0000); cmd(4'h1);
      cmd(4'h2);
      rd(3'd6, v); chk("R9 fast insert when full", v, 16'hFFF9);
      chk("R9 no request", tbl_req, 1'b0);
   endtask

   task automatic t_intr();
      logic [15:0] v;
      wr(3'd7, 16'h0004);
      rd(3'd7, v); chk("R13 enable readback", v, 16'h0004);
      rd(3'd5, v); chk("R13 flag set", v[0], 1'b1);
      wr(3'd7, 16'h0000);
      rd(3'd5, v); chk("R13 flag clear", v[0], 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_code();
      t_uninit();
      t_fast_insert();
      t_queue();
      t_thresh();
      t_match();
      t_delete();
      t_full();
      t_intr();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule